// File: doc/BRIEF.md
# NAND Block-Erase Sequencer

This controller sits on the host side of an 8-bit multiplexed NAND flash bus and erases one block for each request. A one-cycle `start_i` pulse with a 24-bit row address starts the sequence. The block writes the erase-setup command, then the row address one byte per address-latch write, then the erase-confirm command. It then waits while the device holds its ready/busy line low. The wait has a minimum hold-off and an upper bound.

After the busy phase it asks for the status byte and reads it in a single read-enable cycle. It decodes the erase result, the ready bit and the write-protect bit from that byte and ignores the other bits. The device would otherwise stay in status mode, so the controller writes the read-mode command before it reports `done_o`. Write-enable and read-enable pulse widths are set by parameters counted in clock cycles.

The result flags stay valid from the done pulse until the next accepted start.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, `ce_no`, `we_no` and `re_no` are high, `cle_o`, `ale_o`, `io_oe_o`, `done_o`, `busy_o`, `pass_o`, `fail_o`, `wp_err_o` and `timeout_o` are low. Whenever `busy_o` is low, `ce_no`, `we_no` and `re_no` are high.
- R2: Each write is latched on the rising edge of `we_no`. One erase writes these, in this order:
  - command 0x60 with `cle_o`=1 and `ale_o`=0;
  - three address bytes with `ale_o`=1 and `cle_o`=0, row bits [7:0] first, then [15:8], then [23:16];
  - command 0xD0.

  `cle_o` and `ale_o` are never high together.
- R3: Every `we_no` low pulse lasts exactly WE_LOW cycles and every `re_no` low pulse lasts exactly RE_LOW cycles. `we_no` and `re_no` are never low together, and `io_oe_o` is high whenever `we_no` is low.
- R4: After the 0xD0 write, no strobe falls until at least WE_HIGH+TWB_CYC cycles after the rising `we_no` edge of that write. No strobe falls while `busy_n_i` is low, and the sequencer continues only when `busy_n_i` is high.
- R5: After the busy wait, the sequencer writes command 0x70 and then makes exactly one read cycle. During that cycle `io_oe_o` is low and `ce_no` is low. `io_i` is sampled in the last cycle that `re_no` is low.
- R6: `fail_o` = status bit 0 OR NOT status bit 6. Status bit 0 is 1 for a failed erase. Status bit 6 is 1 for ready. Status bits 1 to 5 have no effect on any output.
- R7: `wp_err_o` = NOT status bit 7, where 0 means protected. `pass_o` = NOT `fail_o` AND NOT `wp_err_o`.
- R8: After the status read, command 0x00 is written, and only after that does `done_o` rise. In total, one erase writes exactly seven bytes.
- R9: If `busy_n_i` stays low for TIMEOUT_CYC cycles of the wait, the sequencer ends without a status read or a 0x00 write. It then reports `timeout_o`=1, `fail_o`=1, `pass_o`=0 and `wp_err_o`=0.
- R10: `done_o` is a one-cycle pulse, and `busy_o` is high from the cycle after an accepted start through the done cycle. A `start_i` while `busy_o` is high is ignored. The flags hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Erase request, accepted when idle |
| row_addr_i | input | 24 | Row address of the block to erase |
| busy_n_i | input | 1 | Device ready/busy line, 1 = ready |
| io_i | input | 8 | Data bus input from the device |
| io_o | output | 8 | Data bus output to the device |
| io_oe_o | output | 1 | Output enable for io_o |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write enable, active low |
| re_no | output | 1 | Read enable, active low |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase passed, device not protected |
| fail_o | output | 1 | Erase failed, device not ready, or timeout |
| wp_err_o | output | 1 | Device reported write protection |
| timeout_o | output | 1 | Busy wait exceeded its limit |

## Verification
The assertions assume that `start_i` is a clean synchronous pulse and that `busy_n_i` changes only on clock edges. They also assume the device drives a stable status byte for the whole read-enable pulse. The bench models the device from the strobes it observes. It pulls ready/busy low on the rising write edge of the confirm command and releases it after a chosen number of cycles, or never for the timeout case. It drives the status byte only while both chip enable and read enable are low and drives its complement otherwise, so a sample taken outside that window gives a wrong result. All 256 status values are swept, so the masking of bits 1 to 5 is covered exhaustively.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_CONFIRM, ST_WAIT,
    ST_STATCMD, ST_STATRD, ST_READCMD, ST_DONE
  } seq_state_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_READ_MODE   = 8'h00;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
  parameter int unsigned WE_LOW  = 3,
  parameter int unsigned WE_HIGH = 2,
  parameter int unsigned RE_LOW  = 3,
  parameter int unsigned RE_HIGH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic rd_i,
  output logic we_n_o,
  output logic re_n_o,
  output logic sample_o,
  output logic done_o
);
  localparam int unsigned MAXLEN = (WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH) >
                                   (RE_LOW > RE_HIGH ? RE_LOW : RE_HIGH) ?
                                   (WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH) :
                                   (RE_LOW > RE_HIGH ? RE_LOW : RE_HIGH);
  localparam int unsigned CW = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;
  phase_e     ph_q;
  logic       rd_q;
  logic [CW-1:0] cnt_q, low_last, high_last;

  assign low_last  = rd_q ? CW'(RE_LOW - 1)  : CW'(WE_LOW - 1);
  assign high_last = rd_q ? CW'(RE_HIGH - 1) : CW'(WE_HIGH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_LOW;
          rd_q  <= rd_i;
          cnt_q <= '0;
        end
        PH_LOW: if (cnt_q == low_last) begin
          ph_q  <= PH_HIGH;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_HIGH: if (cnt_q == high_last) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign we_n_o   = !(ph_q == PH_LOW && !rd_q);
  assign re_n_o   = !(ph_q == PH_LOW && rd_q);
  assign sample_o = (ph_q == PH_LOW) && rd_q && (cnt_q == low_last);
  assign done_o   = (ph_q == PH_HIGH) && (cnt_q == high_last);
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int unsigned TWB_CYC     = 10,
  parameter int unsigned TIMEOUT_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rdy_i,
  output logic ready_o,
  output logic expire_o
);
  localparam int unsigned LIMIT = TWB_CYC + TIMEOUT_CYC;
  localparam int unsigned TW    = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;
  logic          holdoff_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i)          cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign holdoff_done = cnt_q >= TW'(TWB_CYC);
  assign ready_o  = active_i && holdoff_done && rdy_i;
  assign expire_o = active_i && !ready_o && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/nand_status_decode.sv
module nand_status_decode (
  input  logic [7:0] stat_i,
  output logic       fail_o,
  output logic       wp_o,
  output logic       pass_o
);
  logic unused_stat_bits;
  assign unused_stat_bits = ^stat_i[5:1];

  assign fail_o = stat_i[0] | ~stat_i[6];
  assign wp_o   = ~stat_i[7];
  assign pass_o = ~fail_o & ~wp_o;
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int unsigned ROW_W       = 24,
  parameter int unsigned WE_LOW      = 3,
  parameter int unsigned WE_HIGH     = 2,
  parameter int unsigned RE_LOW      = 3,
  parameter int unsigned RE_HIGH     = 2,
  parameter int unsigned TWB_CYC     = 10,
  parameter int unsigned TIMEOUT_CYC = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_addr_i,
  input  logic             busy_n_i,
  input  logic [7:0]       io_i,
  output logic [7:0]       io_o,
  output logic             io_oe_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             re_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             wp_err_o,
  output logic             timeout_o
);
  localparam int unsigned ROW_BYTES = ROW_W / 8;
  localparam int unsigned IW        = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;

  seq_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [IW-1:0]    idx_q;
  logic             launched_q, valid_q, to_q;
  logic [7:0]       stat_q;
  logic             issue_st, bus_go, bus_rd, bus_done, bus_sample;
  logic             tmr_ready, tmr_expire;
  logic             dec_fail, dec_wp, dec_pass;

  assign issue_st = state_q inside {ST_SETUP, ST_ADDR, ST_CONFIRM,
                                    ST_STATCMD, ST_STATRD, ST_READCMD};
  assign bus_go   = issue_st && !launched_q;
  assign bus_rd   = (state_q == ST_STATRD);

  nand_bus_cycle #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH)
  ) u_cycle (
    .clk_i, .rst_ni, .go_i(bus_go), .rd_i(bus_rd),
    .we_n_o(we_no), .re_n_o(re_no), .sample_o(bus_sample), .done_o(bus_done)
  );

  nand_wait_timer #(.TWB_CYC(TWB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .active_i(state_q == ST_WAIT), .rdy_i(busy_n_i),
    .ready_o(tmr_ready), .expire_o(tmr_expire)
  );

  nand_status_decode u_dec (
    .stat_i(stat_q), .fail_o(dec_fail), .wp_o(dec_wp), .pass_o(dec_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      idx_q      <= '0;
      launched_q <= 1'b0;
      valid_q    <= 1'b0;
      to_q       <= 1'b0;
      stat_q     <= '0;
    end else begin
      if (bus_go)     launched_q <= 1'b1;
      if (bus_done)   launched_q <= 1'b0;
      if (bus_sample) stat_q     <= io_i;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          row_q   <= row_addr_i;
          idx_q   <= '0;
          valid_q <= 1'b0;
          to_q    <= 1'b0;
        end
        ST_SETUP: if (bus_done) state_q <= ST_ADDR;
        ST_ADDR: if (bus_done) begin
          if (idx_q == IW'(ROW_BYTES - 1)) state_q <= ST_CONFIRM;
          else idx_q <= idx_q + 1'b1;
        end
        ST_CONFIRM: if (bus_done) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tmr_ready) state_q <= ST_STATCMD;
          else if (tmr_expire) begin
            state_q <= ST_DONE;
            to_q    <= 1'b1;
            valid_q <= 1'b1;
          end
        end
        ST_STATCMD: if (bus_done) state_q <= ST_STATRD;
        ST_STATRD:  if (bus_done) state_q <= ST_READCMD;
        ST_READCMD: if (bus_done) begin
          state_q <= ST_DONE;
          valid_q <= 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SETUP:   io_o = CMD_ERASE_SETUP;
      ST_ADDR:    io_o = row_q[{idx_q, 3'b000} +: 8];
      ST_CONFIRM: io_o = CMD_ERASE_CONF;
      ST_STATCMD: io_o = CMD_STATUS;
      ST_READCMD: io_o = CMD_READ_MODE;
      default:    io_o = 8'h00;
    endcase
  end

  assign cle_o     = state_q inside {ST_SETUP, ST_CONFIRM, ST_STATCMD, ST_READCMD};
  assign ale_o     = (state_q == ST_ADDR);
  assign io_oe_o   = cle_o | ale_o;
  assign ce_no     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign timeout_o = valid_q && to_q;
  assign fail_o    = valid_q && (to_q || dec_fail);
  assign wp_err_o  = valid_q && !to_q && dec_wp;
  assign pass_o    = valid_q && !to_q && dec_pass;
endmodule

// File: rtl/nand_erase_seq_checker.sv
module nand_erase_seq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cle_o,
  input logic ale_o,
  input logic ce_no,
  input logic we_no,
  input logic re_no,
  input logic io_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input logic wp_err_o,
  input logic timeout_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && re_no));
  p_latch_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_write_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> io_oe_o);
  p_read_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> (!io_oe_o && !ce_no));
  p_pass_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(pass_o && (fail_o || wp_err_o)));
  p_timeout_fail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (fail_o && !pass_o && !wp_err_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> ($stable(pass_o) && $stable(fail_o) && $stable(wp_err_o)));
endmodule

bind nand_erase_seq nand_erase_seq_checker u_checker (
  .clk_i, .rst_ni, .cle_o, .ale_o, .ce_no, .we_no, .re_no, .io_oe_o,
  .busy_o, .done_o, .pass_o, .fail_o, .wp_err_o, .timeout_o
);

// File: tb/nand_erase_seq_test.sv
`timescale 1ns/1ps
module nand_erase_seq_test;
  localparam int WE_LOW = 2, WE_HIGH = 2, RE_LOW = 3, RE_HIGH = 2;
  localparam int TWB = 3, TMO = 64;

  logic clk = 0, rst_n = 0, start = 0, busy_n;
  logic [23:0] row = '0;
  logic [7:0] io_in, io_out, stat_val = 8'h00;
  logic io_oe, cle, ale, ce_n, we_n, re_n, busy, done, pass, fail, wp, tmo;

  always #5 clk = ~clk;

  nand_erase_seq #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW),
    .RE_HIGH(RE_HIGH), .TWB_CYC(TWB), .TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .row_addr_i(row),
    .busy_n_i(busy_n), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .cle_o(cle), .ale_o(ale), .ce_no(ce_n), .we_no(we_n), .re_no(re_n),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_o(fail),
    .wp_err_o(wp), .timeout_o(tmo));

  // device model
  assign io_in = (!re_n && !ce_n) ? stat_val : ~stat_val;
  int busy_len = 5, busy_cnt = 0;
  logic release_busy = 0;
  assign busy_n = (busy_cnt == 0);

  logic [9:0] log_b [0:15];
  int n_wr = 0, n_rd = 0, proto_err = 0, wait_strobe = 0;
  int lo_we = 0, lo_re = 0, hi_cnt = 0, gap_after_conf = -1;
  logic prev_we = 1, prev_re = 1, last_conf = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!we_n) lo_we <= lo_we + 1;
      if (!re_n) lo_re <= lo_re + 1;
      if (we_n && re_n) hi_cnt <= hi_cnt + 1; else hi_cnt <= 0;
      if (((prev_we && !we_n) || (prev_re && !re_n)) && last_conf) begin
        gap_after_conf <= hi_cnt;
        last_conf <= 0;
      end
      if (!prev_we && we_n) begin
        if (n_wr < 16) log_b[n_wr] <= {cle, ale, io_out};
        n_wr <= n_wr + 1;
        if (lo_we != WE_LOW || !io_oe || (cle && ale)) proto_err <= proto_err + 1;
        lo_we <= 0;
        if (cle && io_out == 8'hD0) begin
          busy_cnt <= busy_len;
          last_conf <= 1;
          hi_cnt <= 0;
        end
      end else if (release_busy) busy_cnt <= 0;
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (!prev_re && re_n) begin
        n_rd <= n_rd + 1;
        if (lo_re != RE_LOW) proto_err <= proto_err + 1;
        lo_re <= 0;
      end
      if (!busy_n && (!we_n || !re_n)) wait_strobe <= wait_strobe + 1;
      prev_we <= we_n;
      prev_re <= re_n;
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_op(input logic [23:0] r, input logic [7:0] s, input int blen,
                        input logic hang, input logic extra_start);
    logic ef, ew, ep;
    int guard;
    @(negedge clk);
    n_wr = 0; n_rd = 0; proto_err = 0; wait_strobe = 0; gap_after_conf = -1;
    row = r; stat_val = s; busy_len = hang ? 1000000 : blen;
    start = 1;
    @(negedge clk);
    start = 0;
    row = ~r;
    chk("R10 busy after start", busy, 1);
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (extra_start && guard == 10) start = 1;
      if (extra_start && guard == 11) start = 0;
    end
    chk("R10 done seen", guard < 3000, 1);
    if (hang) begin
      chk("R9 timeout flag", tmo, 1);
      chk("R9 fail on timeout", fail, 1);
      chk("R9 pass/wp on timeout", {pass, wp}, 2'b00);
      chk("R9 writes before timeout", n_wr, 5);
      chk("R9 no status read", n_rd, 0);
    end else begin
      ef = s[0] | ~s[6]; ew = ~s[7]; ep = ~ef & ~ew;
      chk("R6 fail decode", fail, ef);
      chk("R7 wp decode", wp, ew);
      chk("R7 pass decode", pass, ep);
      chk("R9 no timeout", tmo, 0);
      chk("R8 write count", n_wr, 7);
      chk("R5 read count", n_rd, 1);
      chk("R5 status command", log_b[5], {2'b10, 8'h70});
      chk("R8 read mode command", log_b[6], {2'b10, 8'h00});
      chk("R4 holdoff after confirm", gap_after_conf >= WE_HIGH + TWB, 1);
    end
    chk("R2 setup command", log_b[0], {2'b10, 8'h60});
    chk("R2 address byte 0", log_b[1], {2'b01, r[7:0]});
    chk("R2 address byte 1", log_b[2], {2'b01, r[15:8]});
    chk("R2 address byte 2", log_b[3], {2'b01, r[23:16]});
    chk("R2 confirm command", log_b[4], {2'b10, 8'hD0});
    chk("R3 strobe widths", proto_err, 0);
    chk("R4 no strobe while busy", wait_strobe, 0);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 idle after done", busy, 0);
    chk("R1 idle strobes", {ce_n, we_n, re_n}, 3'b111);
    repeat (3) @(negedge clk);
    chk("R10 flags hold", {pass, fail, wp, tmo}, hang ? 4'b0101 : {ep, ef, ew, 1'b0});
    if (hang) begin
      release_busy = 1;
      @(negedge clk);
      release_busy = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {ce_n, we_n, re_n, cle, ale, io_oe}, 6'b111000);
    chk("R1 reset flags", {done, busy, pass, fail, wp, tmo}, 6'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {ce_n, we_n, re_n, busy}, 4'b1110);
    run_op(24'hA5C381, 8'hC0, 8, 0, 1);
    run_op(24'h123456, 8'hC0, 1, 0, 0);
    for (int i = 0; i < 256; i++)
      run_op({i[7:0], ~i[7:0], i[7:0] ^ 8'h5A}, i[7:0], 5 + (i % 7), 0, 0);
    run_op(24'hFEDCBA, 8'hC0, 0, 1, 0);
    run_op(24'h0F0F0F, 8'hC1, 6, 0, 0);
    summary();
  end
endmodule